// File: doc/BRIEF.md
# Cellular Label Propagation Array

This block labels connected foreground regions of a small binary tile with a grid of identical cells, one cell per pixel. Each foreground cell starts out holding an identifier built from its own row and column. On every clock each cell looks at the labels of its north and west neighbours. If either of them carries a label, the cell takes that label, and the smaller one when both do. If neither does, the cell keeps its own identifier. Background cells always hold zero. Labels therefore flow down and to the right across the grid. No line buffer and no equivalence table are involved.

A one-cycle load strobe captures the whole tile and starts a run. The array then steps once per clock until a step changes no label, and raises a completion flag. After that, any cell's final label can be read by row and column. Because labels travel in only one diagonal direction, a region whose upper-left arms are not joined above or to the left can keep more than one label. Combining tiles and merging such labels belong to the surrounding system.

Top module: `lbl_array`

## Requirements
- R1: While reset is asserted and after its release, until the first load, `done` is low and every in-range read returns zero.
- R2: A foreground cell whose north and west neighbours are both background ends with its own identifier. The identifier is (row+1)·2^XW + (col+1), where XW = clog2(COLS+1), so that zero is never a valid identifier.
- R3: A background cell always reads zero.
- R4: A foreground cell with exactly one foreground neighbour among north and west ends with that neighbour's label.
- R5: A foreground cell whose north and west neighbours are both foreground ends with the smaller of their two labels.
- R6: All cells update together once per clock while running. After k clock edges following the load edge, every label equals k synchronous steps of the rules in R2 to R5 applied to the initial labels.
- R7: `done` rises in the cycle after the first update edge that changed no label. That is at most ROWS+COLS-1 edges after the load edge.
- R8: Once `done` is high it stays high, and no label changes, until the next load.
- R9: A load in any phase, including mid-run, clears `done` at the next edge. It also re-initialises every cell from the new tile and restarts the run.
- R10: `rd_label` is a combinational function of `rd_row` and `rd_col`. A row at or beyond ROWS, or a column at or beyond COLS, returns zero.
- R11: Tile bit index row·COLS + col holds the pixel at that row and column. A 1 marks foreground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe: capture `tile` and start a run |
| tile | input | ROWS*COLS | Binary tile, bit row·COLS+col |
| rd_row | input | RW | Row to read |
| rd_col | input | CW | Column to read |
| rd_label | output | XW+YW | Label of the selected cell, or zero if out of range |
| done | output | 1 | High once labels have stopped changing |

## Verification
The bench builds the array with ROWS=6 and COLS=7. The tile is therefore not square, so a swapped row and column is exposed. COLS+1 exactly fills the 3-bit column field of the identifier. The 3-bit read address fields reach rows 6 and 7 and column 7, which lie outside the array. At 42 cells, a behavioural model of the whole grid can step alongside the design, so `done` and a sweeping read address can be compared on every clock. The final labels are also checked against a row-major fixed-point computation, for tiles that cover isolated pixels, two bars that meet, full and empty tiles, random fills and a reload mid-run.

// File: rtl/lbl_pkg.sv
`timescale 1ns/1ps
package lbl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } ctrl_s;
endpackage

// File: rtl/lbl_pick.sv
`timescale 1ns/1ps
// Chooses the incoming label: the smaller nonzero neighbour label, or the
// cell's own identifier when no neighbour carries one.
module lbl_pick #(
    parameter int IDW = 10
) (
    input  logic [IDW-1:0] north,
    input  logic [IDW-1:0] west,
    input  logic [IDW-1:0] own_id,
    output logic [IDW-1:0] pick
);
    always_comb begin
        if (north != '0 && west != '0) begin
            pick = (north < west) ? north : west;
        end else if (north != '0) begin
            pick = north;
        end else if (west != '0) begin
            pick = west;
        end else begin
            pick = own_id;
        end
    end
endmodule

// File: rtl/lbl_cell.sv
`timescale 1ns/1ps
module lbl_cell #(
    parameter int             IDW    = 10,
    parameter logic [IDW-1:0] OWN_ID = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           tile_bit,
    input  logic           step,
    input  logic [IDW-1:0] north,
    input  logic [IDW-1:0] west,
    output logic [IDW-1:0] label,
    output logic           changed
);
    typedef struct packed {
        logic           fg;
        logic [IDW-1:0] lbl;
    } cell_s;

    cell_s          cell_d, cell_q;
    logic [IDW-1:0] pick;

    lbl_pick #(.IDW(IDW)) u_pick (
        .north  (north),
        .west   (west),
        .own_id (OWN_ID),
        .pick   (pick)
    );

    always_comb begin
        cell_d = cell_q;
        if (load) begin
            cell_d.fg  = tile_bit;
            cell_d.lbl = tile_bit ? OWN_ID : '0;
        end else if (step) begin
            cell_d.lbl = cell_q.fg ? pick : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign label   = cell_q.lbl;
    assign changed = step && (cell_d.lbl != cell_q.lbl);
endmodule

// File: rtl/lbl_read_mux.sv
`timescale 1ns/1ps
module lbl_read_mux #(
    parameter int ROWS  = 20,
    parameter int COLS  = 20,
    parameter int IDW   = 10,
    parameter int RW    = 5,
    parameter int CW    = 5,
    localparam int NCELL = ROWS * COLS
) (
    input  logic [NCELL*IDW-1:0] lbl_flat,
    input  logic [RW-1:0]        rd_row,
    input  logic [CW-1:0]        rd_col,
    output logic [IDW-1:0]       rd_label
);
    int sel;

    always_comb begin
        sel      = int'(rd_row) * COLS + int'(rd_col);
        rd_label = '0;
        if (int'(rd_row) < ROWS && int'(rd_col) < COLS) begin
            rd_label = lbl_flat[sel*IDW +: IDW];
        end
    end
endmodule

// File: rtl/lbl_array.sv
`timescale 1ns/1ps
module lbl_array
    import lbl_pkg::*;
#(
    parameter int  ROWS  = 20,
    parameter int  COLS  = 20,
    localparam int XW    = $clog2(COLS + 1),
    localparam int YW    = $clog2(ROWS + 1),
    localparam int IDW   = XW + YW,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int NCELL = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCELL-1:0] tile,
    input  logic [RW-1:0]    rd_row,
    input  logic [CW-1:0]    rd_col,
    output logic [IDW-1:0]   rd_label,
    output logic             done
);
    logic [NCELL*IDW-1:0] lbl_flat;
    logic [NCELL-1:0]     chg_vec;
    logic                 step;
    logic                 any_change;
    ctrl_s                ctrl_d, ctrl_q;

    assign step       = (ctrl_q.phase == PH_RUN);
    assign any_change = |chg_vec;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int             IDX = r * COLS + c;
            localparam logic [IDW-1:0] CID = IDW'((r + 1) * (2 ** XW) + c + 1);
            logic [IDW-1:0] n_lbl, w_lbl;

            if (r == 0) begin : g_ntop
                assign n_lbl = '0;
            end else begin : g_nin
                assign n_lbl = lbl_flat[(IDX - COLS)*IDW +: IDW];
            end

            if (c == 0) begin : g_wedge
                assign w_lbl = '0;
            end else begin : g_win
                assign w_lbl = lbl_flat[(IDX - 1)*IDW +: IDW];
            end

            lbl_cell #(.IDW(IDW), .OWN_ID(CID)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .tile_bit (tile[IDX]),
                .step     (step),
                .north    (n_lbl),
                .west     (w_lbl),
                .label    (lbl_flat[IDX*IDW +: IDW]),
                .changed  (chg_vec[IDX])
            );
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (load) begin
            ctrl_d.phase = PH_RUN;
        end else if (ctrl_q.phase == PH_RUN && !any_change) begin
            ctrl_d.phase = PH_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign done = (ctrl_q.phase == PH_DONE);

    lbl_read_mux #(
        .ROWS (ROWS), .COLS (COLS), .IDW (IDW), .RW (RW), .CW (CW)
    ) u_rd (
        .lbl_flat (lbl_flat),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .rd_label (rd_label)
    );
endmodule

// File: rtl/lbl_array_chk.sv
`timescale 1ns/1ps
module lbl_array_chk #(
    parameter int ROWS = 20,
    parameter int COLS = 20,
    parameter int IDW  = 10,
    parameter int RW   = 5,
    parameter int CW   = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load,
    input logic           done,
    input logic           any_change,
    input logic [RW-1:0]  rd_row,
    input logic [CW-1:0]  rd_col,
    input logic [IDW-1:0] rd_label
);
    logic        running_q;
    logic [15:0] run_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            run_cnt_q <= '0;
        end else if (load) begin
            running_q <= 1'b1;
            run_cnt_q <= '0;
        end else if (done) begin
            running_q <= 1'b0;
        end else if (running_q) begin
            run_cnt_q <= run_cnt_q + 16'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !done);

    // R7
    done_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (int'(run_cnt_q) < ROWS + COLS));

    // R7
    done_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!any_change));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

    // R8
    label_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (rd_row != $past(rd_row) || rd_col != $past(rd_col)
                             || rd_label == $past(rd_label)));

    // R9
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);

    // R10
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_row) >= ROWS || int'(rd_col) >= COLS) |-> rd_label == '0);
endmodule

bind lbl_array lbl_array_chk #(
    .ROWS (ROWS), .COLS (COLS), .IDW (IDW), .RW (RW), .CW (CW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .done       (done),
    .any_change (any_change),
    .rd_row     (rd_row),
    .rd_col     (rd_col),
    .rd_label   (rd_label)
);

// File: tb/lbl_array_test.sv
`timescale 1ns/1ps
module lbl_array_test;
    localparam int ROWS = 6;
    localparam int COLS = 7;
    localparam int NC   = ROWS * COLS;
    localparam int XW   = 3;
    localparam int IDW  = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load;
    logic [NC-1:0] tile;
    logic [2:0]    rd_row, rd_col;
    logic [IDW-1:0] rd_label;
    logic          done;

    int errors = 0;
    int checks = 0;
    bit auto_rd = 1'b0;

    int m_fg  [ROWS][COLS];
    int m_lab [ROWS][COLS];
    int fp    [ROWS][COLS];
    bit m_run = 1'b0;
    bit m_done = 1'b0;

    always #2.5 clk = ~clk;

    lbl_array #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst_n(rst_n), .load(load), .tile(tile),
        .rd_row(rd_row), .rd_col(rd_col), .rd_label(rd_label), .done(done)
    );

    function automatic int cid(int r, int c);
        return (r + 1) * (1 << XW) + c + 1;
    endfunction

    function automatic int pick_of(int n, int w, int own);
        if (n != 0 && w != 0) return (n < w) ? n : w;
        if (n != 0) return n;
        if (w != 0) return w;
        return own;
    endfunction

    // Behavioural model: whole-grid synchronous step each clock
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    m_fg[r][c] = 0; m_lab[r][c] = 0;
                end
            m_run = 0; m_done = 0;
        end else if (load) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    m_fg[r][c]  = tile[r*COLS+c] ? 1 : 0;
                    m_lab[r][c] = tile[r*COLS+c] ? cid(r, c) : 0;
                end
            m_run = 1; m_done = 0;
        end else if (m_run) begin
            int nx [ROWS][COLS];
            bit chg;
            chg = 0;
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    if (m_fg[r][c] == 0) nx[r][c] = 0;
                    else nx[r][c] = pick_of(r > 0 ? m_lab[r-1][c] : 0,
                                            c > 0 ? m_lab[r][c-1] : 0, cid(r, c));
                    if (nx[r][c] != m_lab[r][c]) chg = 1;
                end
            m_lab = nx;
            if (!chg) begin m_run = 0; m_done = 1; end
        end
    end

    // Per-clock comparison, away from the edges
    always @(posedge clk) begin
        int exp;
        #2;
        checks++;
        if (done !== m_done) begin
            errors++;
            $display("FAIL R7 done per-cycle: got %0b exp %0b", done, m_done);
        end
        if (auto_rd) begin
            exp = (int'(rd_row) < ROWS && int'(rd_col) < COLS) ? m_lab[rd_row][rd_col] : 0;
            checks++;
            if (int'(rd_label) !== exp) begin
                errors++;
                $display("FAIL R6 step label (%0d,%0d): got %0d exp %0d",
                         rd_row, rd_col, rd_label, exp);
            end
            {rd_row, rd_col} = {rd_row, rd_col} + 6'd1;
        end
    end

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic void compute_fp(logic [NC-1:0] p);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                if (!p[r*COLS+c]) fp[r][c] = 0;
                else fp[r][c] = pick_of(r > 0 ? fp[r-1][c] : 0,
                                        c > 0 ? fp[r][c-1] : 0, cid(r, c));
            end
    endfunction

    task automatic do_load(logic [NC-1:0] p);
        @(negedge clk); load = 1'b1; tile = p;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        check("R7 done within ROWS+COLS-1 edges", (n <= ROWS + COLS - 1) ? 1 : 0, 1);
    endtask

    task automatic sweep(string extra);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                string tag;
                int n, w;
                @(negedge clk); rd_row = 3'(r); rd_col = 3'(c); #1;
                n = r > 0 ? fp[r-1][c] : 0;
                w = c > 0 ? fp[r][c-1] : 0;
                if (fp[r][c] == 0) tag = "R3 background";
                else if (n == 0 && w == 0) tag = "R2 own id";
                else if (n != 0 && w != 0) tag = "R5 smaller";
                else tag = "R4 single neighbour";
                check($sformatf("%s %s (%0d,%0d)", tag, extra, r, c), int'(rd_label), fp[r][c]);
            end
    endtask

    task automatic run_tile(logic [NC-1:0] p, string name);
        auto_rd = 1'b1;
        do_load(p);
        wait_done();
        @(negedge clk); auto_rd = 1'b0;
        compute_fp(p);
        sweep(name);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NC-1:0] p;
        rst_n = 1'b0; load = 1'b0; tile = '0; rd_row = '0; rd_col = '0;
        void'($urandom(11));
        // R1: reads during reset
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rd_row = 3'(i % ROWS); rd_col = 3'(i % COLS); #1;
            check("R1 label in reset", int'(rd_label), 0);
        end
        @(negedge clk); rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1 done idle after reset", int'(done), 0);
        end

        // R11: single pixel at row 2 col 5 -> id 3*8+6 = 30
        p = '0; p[2*COLS+5] = 1'b1;
        do_load(p); wait_done();
        @(negedge clk); rd_row = 3'd2; rd_col = 3'd5; #1;
        check("R11 pixel index / R2 id at (2,5)", int'(rd_label), 30);
        @(negedge clk); rd_row = 3'd5; rd_col = 3'd2; #1;
        check("R11 transposed cell empty", int'(rd_label), 0);

        // Two vertical bars joined at the bottom: R5 merge
        p = '0;
        for (int r = 0; r < 5; r++) begin p[r*COLS+1] = 1'b1; p[r*COLS+4] = 1'b1; end
        for (int c = 1; c <= 4; c++) p[5*COLS+c] = 1'b1;
        run_tile(p, "bars");
        @(negedge clk); rd_row = 3'd5; rd_col = 3'd4; #1;
        check("R5 join cell takes left bar id 10", int'(rd_label), 10);

        run_tile('1, "full");
        run_tile('0, "empty");
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NC; i++) p[i] = (($urandom % 10) < 6);
            run_tile(p, $sformatf("rand%0d", k));
        end

        // R8: done sticky, labels frozen
        repeat (6) @(negedge clk);
        check("R8 done held", int'(done), 1);
        sweep("R8 frozen");

        // R10: out-of-range reads
        @(negedge clk); rd_row = 3'd6; rd_col = 3'd0; #1;
        check("R10 row 6 reads zero", int'(rd_label), 0);
        @(negedge clk); rd_row = 3'd7; rd_col = 3'd3; #1;
        check("R10 row 7 reads zero", int'(rd_label), 0);
        @(negedge clk); rd_row = 3'd0; rd_col = 3'd7; #1;
        check("R10 col 7 reads zero", int'(rd_label), 0);

        // R9: reload mid-run
        do_load('1);
        @(negedge clk);
        p = '0;
        for (int i = 0; i < NC; i += 3) p[i] = 1'b1;
        do_load(p);
        check("R9 done low after reload", int'(done), 0);
        wait_done();
        compute_fp(p);
        sweep("R9 reload");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule